// File: doc/BRIEF.md
# Periodic Wakeup Down-Counter

This block raises a periodic wakeup event from a slow real-time clock. A down-counter is loaded with a programmed reload value and counts ticks. Each time it reaches zero it reloads and sets a sticky event flag. The tick comes from one of two places: the RTC clock divided by 16, 8, 4 or 2, or a one-pulse-per-second strobe that arrives on an input. The same 3-bit select code also changes the width of the count. With the two upper select bits both set, the reload value gains a 17th bit worth 2^16, which allows periods of up to 131072 seconds.

Software programs the block through a single write strobe. Each write carries the reload value, select code, enable bit and interrupt-enable bit together. The enable and interrupt-enable bits are taken on every write. The reload value and select code are taken only while the write-allowed output is high. That output is low whenever the timer is enabled, and it returns high two RTC clock cycles after the timer is disabled. The flag is cleared by a separate one-cycle clear strobe. The interrupt output is the flag gated by the interrupt enable. Each write strobe, clear strobe and second strobe acts in the single clock cycle in which it is high. All control and status pins are plain levels or strobes, with no handshake.

Top module: `wkup_timer`

## Requirements
- R1: After reset, flag and irq are 0 and wr_ok is 1. The stored reload value is 0, the select code is 000, and the enable and interrupt-enable bits are 0.
- R2: Select codes 000, 001, 010 and 011 tick once every 16, 8, 4 and 2 clock cycles. The divider restarts when the timer is enabled. With reload value R and divide factor N, the flag first sets (R+1)*N cycles after the edge that stores enable=1, and again every (R+1)*N cycles after that.
- R3: Select codes 100 and 101 count one tick per clock cycle in which sec_strobe is high, so R+1 strobes set the flag. Select codes 110 and 111 count in the same way but reload R + 65536, so the flag sets after R + 65537 strobes.
- R4: The flag stays set until a cycle with flag_clr high clears it. If flag_clr is high in the same cycle as an expiry, the flag stays (or becomes) 1.
- R5: irq is 1 exactly when the flag is 1 and the stored interrupt-enable bit is 1.
- R6: wr_ok is 0 from the edge that stores enable=1. After the edge that stores enable=0, wr_ok stays 0 for one more cycle and is 1 from the second edge on.
- R7: A write made while wr_ok is 0 leaves the reload value and the select code unchanged, but it still updates the enable and interrupt-enable bits.
- R8: A write of reload value 0 with select code 011 leaves the stored reload value and select code unchanged. The enable and interrupt-enable bits from that write still take effect.
- R9: While disabled, the timer never sets the flag. A flag that is already set stays set until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | One-cycle configuration write strobe |
| cfg_reload | input | RL_W | Reload value carried by the write |
| cfg_sel | input | 3 | Tick source and width select carried by the write |
| cfg_en | input | 1 | Timer enable carried by the write |
| cfg_ie | input | 1 | Interrupt enable carried by the write |
| flag_clr | input | 1 | One-cycle strobe that clears the flag |
| sec_strobe | input | 1 | One-per-second tick strobe |
| flag | output | 1 | Sticky expiry flag |
| irq | output | 1 | Flag gated by the interrupt enable |
| wr_ok | output | 1 | High while a reload value and select code may be written |

## Verification
Two pairs of actions can land in the same cycle.

- A clear strobe and a counter expiry. The bench runs the timer at its shortest legal period, so an expiry falls every fourth cycle. It then places one clear strobe between expiries and one exactly on an expiry edge. The first clear must leave the flag at 0; the second must leave it at 1.
- A configuration write and an enable change. The bench enables and reconfigures in a single write, disables and reconfigures in a single write, and enables with the forbidden pair. Each of these is judged only by the expiry period that follows, counted in cycles from the enabling edge.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  // Number of divider stages; the two low select bits pick one of them.
  localparam int DIV_W = 4;
  localparam int SEL_W = 3;
  // Select code that is illegal together with a zero reload value.
  localparam logic [SEL_W-1:0] SEL_FASTEST = 3'b011;
endpackage

// File: rtl/wkt_cfg.sv
module wkt_cfg
  import wkt_pkg::*;
#(
  parameter int RL_W    = 16,
  parameter int WOK_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [RL_W-1:0]  cfg_reload,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_en,
  input  logic             cfg_ie,
  output logic             en_q,
  output logic             ie_q,
  output logic [SEL_W-1:0] sel_q,
  output logic [RL_W:0]    rl_full,
  output logic [RL_W:0]    ld_val,
  output logic             wr_ok
);
  localparam int DW = $clog2(WOK_DLY + 1);

  logic [RL_W-1:0]  rl_q, rl_nxt;
  logic [SEL_W-1:0] sel_nxt;
  logic [DW-1:0]    dly_q;
  logic             forbid, take;

  assign forbid = (cfg_reload == '0) && (cfg_sel == SEL_FASTEST);
  assign take   = cfg_we && wr_ok && !forbid;

  always_comb begin
    rl_nxt  = take ? cfg_reload : rl_q;
    sel_nxt = take ? cfg_sel    : sel_q;
  end

  // The 17th count bit is only present for select codes 11x.
  assign ld_val  = {sel_nxt[2] & sel_nxt[1], rl_nxt};
  assign rl_full = {sel_q[2] & sel_q[1], rl_q};
  assign wr_ok   = !en_q && (dly_q == DW'(WOK_DLY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rl_q  <= '0;
      sel_q <= '0;
      en_q  <= 1'b0;
      ie_q  <= 1'b0;
      dly_q <= DW'(WOK_DLY);
    end else begin
      rl_q  <= rl_nxt;
      sel_q <= sel_nxt;
      if (cfg_we) begin
        en_q <= cfg_en;
        ie_q <= cfg_ie;
      end
      if (en_q)
        dly_q <= '0;
      else if (dly_q != DW'(WOK_DLY))
        dly_q <= dly_q + 1'b1;
    end
  end
endmodule

// File: rtl/wkt_tick.sv
module wkt_tick
  import wkt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_q,
  input  logic [SEL_W-1:0] sel_q,
  input  logic             sec_strobe,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] tap;

  // tap[k] is high once every 2^(k+1) cycles of the running divider.
  for (genvar k = 0; k < DIV_W; k++) begin : g_tap
    assign tap[k] = &div_q[k:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      div_q <= '0;
    else if (!en_q)
      div_q <= '0;
    else
      div_q <= div_q + 1'b1;
  end

  assign tick = en_q && (sel_q[2] ? sec_strobe : tap[DIV_W-1-int'(sel_q[1:0])]);
endmodule

// File: rtl/wkt_count.sv
module wkt_count #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_q,
  input  logic             tick,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] rl_full,
  input  logic             flag_clr,
  output logic             expire,
  output logic             flag
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flag  <= 1'b0;
    end else begin
      if (!en_q)
        cnt_q <= ld_val;
      else if (tick)
        cnt_q <= (cnt_q == '0) ? rl_full : cnt_q - 1'b1;
      flag <= expire | (flag & ~flag_clr);
    end
  end
endmodule

// File: rtl/wkup_timer.sv
module wkup_timer
  import wkt_pkg::*;
#(
  parameter int RL_W    = 16,
  parameter int WOK_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [RL_W-1:0]  cfg_reload,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_en,
  input  logic             cfg_ie,
  input  logic             flag_clr,
  input  logic             sec_strobe,
  output logic             flag,
  output logic             irq,
  output logic             wr_ok
);
  localparam int CNT_W = RL_W + 1;

  logic             en_q, ie_q, tick, expire;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] rl_full, ld_val;

  wkt_cfg #(.RL_W(RL_W), .WOK_DLY(WOK_DLY)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_reload(cfg_reload),
    .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_ie(cfg_ie), .en_q(en_q),
    .ie_q(ie_q), .sel_q(sel_q), .rl_full(rl_full), .ld_val(ld_val),
    .wr_ok(wr_ok)
  );

  wkt_tick u_tick (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .sel_q(sel_q),
    .sec_strobe(sec_strobe), .tick(tick)
  );

  wkt_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .tick(tick), .ld_val(ld_val),
    .rl_full(rl_full), .flag_clr(flag_clr), .expire(expire), .flag(flag)
  );

  assign irq = flag & ie_q;
endmodule

// File: rtl/wkup_timer_chk.sv
module wkup_timer_chk #(
  parameter int RL_W = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_q,
  input logic [2:0]    sel_q,
  input logic [RL_W:0] rl_full,
  input logic          expire,
  input logic          flag_clr,
  input logic          flag,
  input logic          irq,
  input logic          wr_ok
);
  a_r6_wok_low_on: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> !wr_ok);

  a_r6_wok_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |=> !wr_ok);

  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> ($stable(rl_full) && $stable(sel_q)));

  a_r8_no_forbidden: assert property (@(posedge clk) disable iff (!rst_n)
    !((rl_full[RL_W-1:0] == '0) && (sel_q == 3'b011)));

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !expire) |=> !flag);

  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> !irq);

  a_r9_set_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(en_q));
endmodule

bind wkup_timer wkup_timer_chk #(.RL_W(RL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .sel_q(sel_q), .rl_full(rl_full),
  .expire(expire), .flag_clr(flag_clr), .flag(flag), .irq(irq), .wr_ok(wr_ok)
);

// File: tb/wkup_timer_tb.sv
`timescale 1ns/1ps
module wkup_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_reload = '0;
  logic [2:0]  cfg_sel = '0;
  logic        cfg_en = 1'b0;
  logic        cfg_ie = 1'b0;
  logic        flag_clr = 1'b0;
  logic        sec_strobe = 1'b0;
  logic        flag, irq, wr_ok;
  int          nchk = 0;
  int          nerr = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  wkup_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_reload(cfg_reload),
    .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_ie(cfg_ie), .flag_clr(flag_clr),
    .sec_strobe(sec_strobe), .flag(flag), .irq(irq), .wr_ok(wr_ok)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] rl, input logic [2:0] sl,
                          input logic en, input logic ie);
    cfg_we = 1'b1; cfg_reload = rl; cfg_sel = sl; cfg_en = en; cfg_ie = ie;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic pulse_sec();
    sec_strobe = 1'b1;
    @(negedge clk);
    sec_strobe = 1'b0;
  endtask

  // Flag must be 0 after cycle n-1 and 1 after cycle n from now.
  task automatic wait_flag(input int n, input string tag);
    wait_n(n - 1);
    chk({tag, " flag before expiry"}, flag, 1'b0);
    wait_n(1);
    chk({tag, " flag at expiry"}, flag, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 flag after reset", flag, 1'b0);
    chk("R1 irq after reset", irq, 1'b0);
    chk("R1 wr_ok after reset", wr_ok, 1'b1);
  endtask

  task automatic t_divider(input logic [2:0] sl, input int rl, input int nd, input logic ie);
    int p;
    p = (rl + 1) * nd;
    do_write(16'(rl), sl, 1'b0, ie);
    do_write(16'(rl), sl, 1'b1, ie);
    chk("R6 wr_ok low once enabled", wr_ok, 1'b0);
    wait_flag(p, "R2 first period");
    chk("R5 irq follows flag and enable", irq, ie);
    pulse_clr();
    chk("R4 flag cleared", flag, 1'b0);
    wait_flag(p - 1, "R2 second period");
    do_write(16'(rl), sl, 1'b0, ie);
    chk("R6 wr_ok low right after disable", wr_ok, 1'b0);
    wait_n(1);
    chk("R6 wr_ok low one cycle after disable", wr_ok, 1'b0);
    wait_n(1);
    chk("R6 wr_ok high two cycles after disable", wr_ok, 1'b1);
    wait_n(20);
    chk("R9 flag kept while disabled", flag, 1'b1);
    pulse_clr();
    wait_n(2 * p);
    chk("R9 no expiry while disabled", flag, 1'b0);
  endtask

  task automatic t_sec_short();
    do_write(16'd3, 3'b100, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) begin
      pulse_sec();
      wait_n(5);
    end
    chk("R3 no expiry after three strobes", flag, 1'b0);
    pulse_sec();
    chk("R3 expiry on fourth strobe", flag, 1'b1);
    do_write(16'd3, 3'b100, 1'b0, 1'b1);
    wait_n(2);
    pulse_clr();
  endtask

  task automatic t_sec_extended();
    do_write(16'd2, 3'b110, 1'b1, 1'b0);
    sec_strobe = 1'b1;
    wait_flag(65539, "R3 extended count");
    sec_strobe = 1'b0;
    do_write(16'd2, 3'b110, 1'b0, 1'b0);
    wait_n(2);
    pulse_clr();
  endtask

  task automatic t_collide();
    do_write(16'd0, 3'b010, 1'b0, 1'b0);
    do_write(16'd0, 3'b010, 1'b1, 1'b0);
    wait_flag(4, "R4 short period");
    pulse_clr();
    chk("R4 clear between expiries", flag, 1'b0);
    wait_n(2);
    pulse_clr();
    chk("R4 set wins over same-cycle clear", flag, 1'b1);
    do_write(16'd0, 3'b010, 1'b0, 1'b0);
    wait_n(2);
    pulse_clr();
  endtask

  task automatic t_locked();
    do_write(16'd1, 3'b000, 1'b0, 1'b0);
    do_write(16'd1, 3'b000, 1'b1, 1'b0);
    do_write(16'd5, 3'b001, 1'b1, 1'b0);
    wait_flag(31, "R7 write while running ignored");
    do_write(16'd5, 3'b001, 1'b0, 1'b0);
    wait_n(2);
    chk("R6 wr_ok back high", wr_ok, 1'b1);
    pulse_clr();
    do_write(16'd0, 3'b011, 1'b1, 1'b0);
    wait_flag(32, "R8 forbidden pair ignored and R7 disable write ignored");
    do_write(16'd1, 3'b000, 1'b0, 1'b0);
    wait_n(2);
    pulse_clr();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_divider(3'b000, 2, 16, 1'b1);
    t_divider(3'b001, 3, 8, 1'b0);
    t_divider(3'b010, 1, 4, 1'b1);
    t_divider(3'b011, 5, 2, 1'b0);
    t_sec_short();
    t_collide();
    t_locked();
    t_sec_extended();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule